// File: doc/BRIEF.md
# Framed 4B/5B Transmit Symbol Encoder

This block sits between a MAC-side nibble interface and a downstream scrambler in a 100 Mb/s copper transmit path. Each clock, at the 25 MHz nibble rate, it takes a 4-bit nibble, a transmit-enable strobe and a transmit-error flag. It emits one registered 5-bit code-group. While enable is high, data nibbles pass through a fixed sixteen-entry mapping. The block also frames the stream itself: the first two enabled slots become the start-of-stream delimiter pair, and the two slots after enable drops become the end-of-stream delimiter pair. The idle code-group fills the gaps between frames.

A compile-time parameter picks the order in which the five code bits sit on the output bus. This lets the block feed a serializer that shifts out bit 0 first, or one that shifts out bit 4 first. A four-state framing controller tracks where the stream is. A combinational selector picks the code-group. The top module reorders the bits and registers the result.

Top module: `mii4b5b_tx_encoder`

## Requirements
- R1: In data slots, nibbles map to code-groups as follows. Each code-group is written with its first-transmitted bit on the left. 0→11110, 1→01001, 2→10100, 3→10101, 4→01010, 5→01011, 6→01110, 7→01111, 8→10010, 9→10011, A→10110, B→10111, C→11010, D→11011, E→11100, F→11101.
- R2: When LSB_FIRST=1, output bit 0 carries the leftmost (first-transmitted) bit of the code-group and bit 4 carries the rightmost. When LSB_FIRST=0, bit 4 carries the leftmost bit.
- R3: Inputs sampled at a rising clock edge determine the code-group presented just after that edge. The output holds that value until the next edge.
- R4: The idle code-group 11111 is emitted while enable is low and no end delimiter is pending.
- R5: The first enabled slot after idle emits /J/ = 11000, and the second emits /K/ = 10001. The nibbles offered in those two slots are discarded.
- R6: After at least two enabled slots, the first slot with enable low emits /T/ = 01101 and the next emits /R/ = 00111. Idle follows.
- R7: Error high in a data slot (third or later enabled slot) emits /H/ = 00100 in place of the data code-group. Error has no effect in idle, /J/ or /K/ slots.
- R8: If enable drops in the /K/ slot, /T/ is sent instead of /K/, and /R/ follows.
- R9: The /R/ slot is always sent, whatever the enable level. If enable is high in the slot after /R/, a new frame opens there with /J/.
- R10: Synchronous active-high reset makes the next output the idle code-group and returns framing to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Nibble-rate clock |
| rst | input | 1 | Synchronous reset, active high |
| tx_en | input | 1 | Transmit enable; nibble valid while high |
| tx_er | input | 1 | Transmit error; forces /H/ in data slots |
| txd | input | 4 | Transmit nibble |
| tx_code | output | 5 | Registered code-group toward the scrambler |

## Verification
The bench builds two copies of the encoder side by side: one with LSB_FIRST=1 and one with LSB_FIRST=0. Every code-group is therefore checked under both bit orderings against a bit reversal that the bench computes itself. The nibble space is small enough to sweep completely: a single long frame carries all sixteen data values. The remaining framing corner cases are each driven on purpose: a one-slot frame, a two-slot frame, errors in every slot type, re-enable during /R/, and reset in the middle of a frame.

// File: rtl/mii4b5b_pkg.sv
package mii4b5b_pkg;
  localparam int NIB_W  = 4;
  localparam int CODE_W = 5;

  typedef logic [CODE_W-1:0] cg_t;
  typedef logic [NIB_W-1:0]  nib_t;

  // code-groups written first-transmitted bit on the left (MSB)
  localparam cg_t CG_IDLE = 5'b11111;
  localparam cg_t CG_J    = 5'b11000;
  localparam cg_t CG_K    = 5'b10001;
  localparam cg_t CG_T    = 5'b01101;
  localparam cg_t CG_R    = 5'b00111;
  localparam cg_t CG_H    = 5'b00100;

  typedef enum logic [1:0] {
    FR_IDLE  = 2'd0,
    FR_SSD2  = 2'd1,
    FR_DATA  = 2'd2,
    FR_ESD2  = 2'd3
  } frame_st_e;

  function automatic cg_t data_cg(input nib_t n);
    cg_t c;
    case (n)
      4'h0: c = 5'b11110;
      4'h1: c = 5'b01001;
      4'h2: c = 5'b10100;
      4'h3: c = 5'b10101;
      4'h4: c = 5'b01010;
      4'h5: c = 5'b01011;
      4'h6: c = 5'b01110;
      4'h7: c = 5'b01111;
      4'h8: c = 5'b10010;
      4'h9: c = 5'b10011;
      4'hA: c = 5'b10110;
      4'hB: c = 5'b10111;
      4'hC: c = 5'b11010;
      4'hD: c = 5'b11011;
      4'hE: c = 5'b11100;
      default: c = 5'b11101;
    endcase
    return c;
  endfunction

  // place the first-transmitted bit at bit 0 when lsb_first is set
  function automatic cg_t wire_order(input cg_t c, input bit lsb_first);
    cg_t r;
    for (int i = 0; i < CODE_W; i++) begin
      r[i] = lsb_first ? c[CODE_W-1-i] : c[i];
    end
    return r;
  endfunction
endpackage

// File: rtl/mii4b5b_frame_fsm.sv
module mii4b5b_frame_fsm
  import mii4b5b_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      tx_en,
  output frame_st_e state,
  output logic      ev_sof,
  output logic      ev_eof
);
  frame_st_e nxt;

  assign ev_sof = (state == FR_IDLE) && tx_en;
  assign ev_eof = ((state == FR_SSD2) || (state == FR_DATA)) && !tx_en;

  always_comb begin
    nxt = state;
    case (state)
      FR_IDLE: if (tx_en) nxt = FR_SSD2;
      FR_SSD2: nxt = tx_en ? FR_DATA : FR_ESD2;
      FR_DATA: if (!tx_en) nxt = FR_ESD2;
      default: nxt = FR_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state <= FR_IDLE;
    else     state <= nxt;
  end
endmodule

// File: rtl/mii4b5b_symbol_sel.sv
module mii4b5b_symbol_sel
  import mii4b5b_pkg::*;
(
  input  frame_st_e state,
  input  logic      tx_en,
  input  logic      tx_er,
  input  nib_t      txd,
  output cg_t       cg
);
  always_comb begin
    case (state)
      FR_IDLE: cg = tx_en ? CG_J : CG_IDLE;
      FR_SSD2: cg = tx_en ? CG_K : CG_T;
      FR_DATA: cg = !tx_en ? CG_T : (tx_er ? CG_H : data_cg(txd));
      default: cg = CG_R;
    endcase
  end
endmodule

// File: rtl/mii4b5b_tx_encoder.sv
module mii4b5b_tx_encoder
  import mii4b5b_pkg::*;
#(
  parameter bit LSB_FIRST = 1'b1
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       tx_en,
  input  logic       tx_er,
  input  logic [3:0] txd,
  output logic [4:0] tx_code
);
  localparam cg_t IDLE_W = wire_order(CG_IDLE, LSB_FIRST);

  frame_st_e state;
  logic      ev_sof, ev_eof;
  logic      st_idle, st_data;
  cg_t       cg_sel, cg_wire;

  assign st_idle = (state == FR_IDLE);
  assign st_data = (state == FR_DATA);

  mii4b5b_frame_fsm fsm_i (
    .clk(clk), .rst(rst), .tx_en(tx_en),
    .state(state), .ev_sof(ev_sof), .ev_eof(ev_eof)
  );

  mii4b5b_symbol_sel sel_i (
    .state(state), .tx_en(tx_en), .tx_er(tx_er), .txd(txd), .cg(cg_sel)
  );

  generate
    if (LSB_FIRST) begin : g_lsb
      for (genvar b = 0; b < CODE_W; b++) begin : g_bit
        assign cg_wire[b] = cg_sel[CODE_W-1-b];
      end
    end else begin : g_msb
      assign cg_wire = cg_sel;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) tx_code <= IDLE_W;
    else     tx_code <= cg_wire;
  end
endmodule

// File: rtl/mii4b5b_tx_encoder_chk.sv
module mii4b5b_tx_encoder_chk
  import mii4b5b_pkg::*;
#(
  parameter bit LSB_FIRST = 1'b1
) (
  input logic       clk,
  input logic       rst,
  input logic       tx_en,
  input logic       tx_er,
  input logic [4:0] tx_code,
  input logic       st_idle,
  input logic       st_data
);
  localparam cg_t IW = wire_order(CG_IDLE, LSB_FIRST);
  localparam cg_t JW = wire_order(CG_J, LSB_FIRST);
  localparam cg_t KW = wire_order(CG_K, LSB_FIRST);
  localparam cg_t TW = wire_order(CG_T, LSB_FIRST);
  localparam cg_t RW = wire_order(CG_R, LSB_FIRST);
  localparam cg_t HW = wire_order(CG_H, LSB_FIRST);

  p_reset_idle_r10: assert property (@(posedge clk) rst |=> tx_code == IW);
  p_idle_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (st_idle && !tx_en) |=> tx_code == IW);
  p_sof_j_r5: assert property (@(posedge clk) disable iff (rst)
    (st_idle && tx_en) |=> tx_code == JW);
  p_k_after_j_r5: assert property (@(posedge clk) disable iff (rst)
    (tx_code == JW && tx_en) |=> tx_code == KW);
  p_t_then_r_r6: assert property (@(posedge clk) disable iff (rst)
    (tx_code == TW) |=> tx_code == RW);
  p_err_h_r7: assert property (@(posedge clk) disable iff (rst)
    (st_data && tx_en && tx_er) |=> tx_code == HW);
  p_after_r_r9: assert property (@(posedge clk) disable iff (rst)
    (tx_code == RW) |=> (tx_code == IW || tx_code == JW));
endmodule

bind mii4b5b_tx_encoder mii4b5b_tx_encoder_chk #(.LSB_FIRST(LSB_FIRST)) chk_i (
  .clk(clk), .rst(rst), .tx_en(tx_en), .tx_er(tx_er),
  .tx_code(tx_code), .st_idle(st_idle), .st_data(st_data)
);

// File: tb/mii4b5b_tx_encoder_tb_top.sv
module mii4b5b_tx_encoder_tb_top;
  localparam int CLK_PERIOD = 40;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tx_en = 1'b0;
  logic       tx_er = 1'b0;
  logic [3:0] txd = 4'h0;
  logic [4:0] code_l, code_m;

  int checks = 0;
  int failures = 0;
  logic [4:0] prev_exp = 5'b11111;

  always #(CLK_PERIOD/2) clk = ~clk;

  mii4b5b_tx_encoder #(.LSB_FIRST(1'b1)) dut_i (
    .clk(clk), .rst(rst), .tx_en(tx_en), .tx_er(tx_er), .txd(txd), .tx_code(code_l));
  mii4b5b_tx_encoder #(.LSB_FIRST(1'b0)) dut_m_i (
    .clk(clk), .rst(rst), .tx_en(tx_en), .tx_er(tx_er), .txd(txd), .tx_code(code_m));

  // expected code-groups, leftmost = first transmitted (R1, R4..R7)
  localparam logic [4:0] XI = 5'b11111, XJ = 5'b11000, XK = 5'b10001;
  localparam logic [4:0] XT = 5'b01101, XR = 5'b00111, XH = 5'b00100;
  logic [4:0] tbl [16] = '{5'b11110, 5'b01001, 5'b10100, 5'b10101,
                           5'b01010, 5'b01011, 5'b01110, 5'b01111,
                           5'b10010, 5'b10011, 5'b10110, 5'b10111,
                           5'b11010, 5'b11011, 5'b11100, 5'b11101};

  function automatic logic [4:0] flip(input logic [4:0] c);
    logic [4:0] r;
    for (int i = 0; i < 5; i++) r[i] = c[4-i];
    return r;
  endfunction

  task automatic check(input logic [4:0] exp, input string tag);
    checks++;
    if (code_l !== flip(exp)) begin
      failures++;
      $display("FAIL %s R2 lsb-first: actual=%b expected=%b", tag, code_l, flip(exp));
    end
    checks++;
    if (code_m !== exp) begin
      failures++;
      $display("FAIL %s R2 msb-first: actual=%b expected=%b", tag, code_m, exp);
    end
  endtask

  // drive one slot; R3: output unchanged before the edge, new after it
  task automatic step(input logic en, input logic er, input logic [3:0] d,
                      input logic [4:0] exp, input string tag);
    @(negedge clk);
    tx_en = en; tx_er = er; txd = d;
    #1 check(prev_exp, "R3 hold");
    @(posedge clk);
    #1 check(exp, tag);
    prev_exp = exp;
  endtask

  task automatic frame(input int len, input int base, input logic [31:0] errs);
    for (int i = 0; i < len; i++) begin
      logic [3:0] n;
      logic [4:0] e;
      n = 4'((base + i) % 16);
      if (i == 0)       e = XJ;
      else if (i == 1)  e = XK;
      else if (errs[i]) e = XH;
      else              e = tbl[n];
      step(1'b1, errs[i], n, e, (i < 2) ? "R5/R7 delimiter" : (errs[i] ? "R7 error" : "R1 data"));
    end
    step(1'b0, 1'b0, 4'h3, (len == 1) ? XT : XT, (len == 1) ? "R8 short T" : "R6 end T");
    step(1'b0, 1'b0, 4'h9, XR, "R6 end R");
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    rst = 1'b1;
    step(1'b0, 1'b0, 4'h0, XI, "R10 reset");
    step(1'b1, 1'b1, 4'h5, XI, "R10 reset held");
    rst = 1'b0;
    // R4/R7: idle with noise on nibble and error
    step(1'b0, 1'b1, 4'hA, XI, "R4 idle");
    step(1'b0, 1'b0, 4'h6, XI, "R4 idle");
    // R1: all sixteen data values in one frame
    frame(18, 0, 32'h0);
    step(1'b0, 1'b0, 4'h0, XI, "R4 after R");
    // R7: error in J, K and several data slots
    frame(8, 5, 32'b1010_0111);
    // R8: enable dropped in the K slot; one-slot frame
    frame(1, 7, 32'h0);
    step(1'b0, 1'b0, 4'h0, XI, "R8 idle after");
    // two-slot frame: J, K, T, R
    frame(2, 2, 32'h0);
    // R9: re-enable during R slot
    frame(4, 9, 32'h0);
    step(1'b1, 1'b0, 4'h6, XJ, "R9 J after R");
    step(1'b1, 1'b0, 4'h7, XK, "R9 K");
    step(1'b1, 1'b0, 4'h8, tbl[8], "R9 data");
    step(1'b0, 1'b0, 4'h0, XT, "R9 T");
    // R9: enable high in the R slot itself
    step(1'b1, 1'b0, 4'h4, XR, "R9 R kept");
    step(1'b0, 1'b0, 4'h0, XI, "R9 idle");
    // R10: reset mid-frame, then restart
    step(1'b1, 1'b0, 4'h1, XJ, "R5 J");
    step(1'b1, 1'b0, 4'h2, XK, "R5 K");
    step(1'b1, 1'b0, 4'hC, tbl[12], "R1 data");
    rst = 1'b1;
    step(1'b1, 1'b0, 4'hD, XI, "R10 mid-frame reset");
    rst = 1'b0;
    step(1'b1, 1'b0, 4'hE, XJ, "R10 restart J");
    step(1'b1, 1'b0, 4'hF, XK, "R10 restart K");
    step(1'b1, 1'b0, 4'hF, tbl[15], "R1 data");
    step(1'b0, 1'b0, 4'h0, XT, "R6 T");
    step(1'b0, 1'b0, 4'h0, XR, "R6 R");
    step(1'b0, 1'b0, 4'h0, XI, "R4 idle");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule